// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with First-Word Prefetch

A single-clock FIFO whose read-side protocol is fixed at master reset. A mode pin, sampled while reset is held, selects one of two behaviours that then persist until the next reset. In request mode every word, the very first one included, is moved into the registered data output only by a read-enabled clock edge. The two flags then report "holds data" and "has space". In prefetch mode the oldest word is pushed into the output register automatically as soon as it is in memory. A read-enabled edge consumes the word on display and brings the next one forward. The two flags then report "output valid" and "input accepts", each active low.

Both enables are active low. A read of an empty store and a write to a full store are ignored. While the read enable is inactive, the output register keeps its value. In prefetch mode the word held in the output register still counts toward capacity until it is consumed, so both modes hold at most `DEPTH` words in total.

The read controller is a three-state machine. `ST_REQ` is request mode and never leaves itself. `ST_PF_IDLE` is prefetch mode with no valid output. Its transition *autoload* to `ST_PF_SHOW` fires when memory is non-empty. `ST_PF_SHOW` is prefetch mode with a valid output. On a read it either stays (transition *advance*, when memory still holds a word) or returns to `ST_PF_IDLE` (transition *drain*, when memory is empty). At reset the state is set to `ST_REQ` or `ST_PF_IDLE` from the mode pin.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode pin is sampled only while `rst_n` is low: 0 selects request mode and 1 selects prefetch mode. Changing the pin after reset has no effect until the next reset.
- R2: Right after reset `rd_data` is 0. In request mode `rd_flag`=0 (no data) and `wr_flag`=1 (space). In prefetch mode `rd_flag`=1 (output not valid) and `wr_flag`=0 (ready for input).
- R3: In request mode, `rd_flag` is 1 exactly when at least one word is stored and `wr_flag` is 0 exactly when `DEPTH` words are stored. Both reflect the accesses of an edge immediately after that edge.
- R4: In request mode, `rd_data` changes only on an edge where `rd_n`=0 and data is stored, and it then takes the oldest stored word. This applies to the first word after empty as well.
- R5: In prefetch mode, a word written into an empty FIFO appears on `rd_data`, with `rd_flag` falling to 0, after the next clock edge following the write edge, without any read request.
- R6: In prefetch mode, an edge with `rd_n`=0 while `rd_flag`=0 consumes the shown word. If another word is stored, it is shown after that edge. Otherwise `rd_flag` rises to 1 and `rd_data` keeps the consumed value.
- R7: In prefetch mode, the shown word counts toward capacity: `wr_flag` is 1 exactly when the stored words plus the shown word total `DEPTH`.
- R8: A read request while nothing can be read leaves `rd_data` and both flags unchanged.
- R9: A write request while the FIFO is full is dropped. The dropped word never appears at the output, and no stored word is lost.
- R10: A read on a full FIFO frees a slot. After that edge the full indication is removed, so that the next write is accepted.
- R11: Words leave in the order they were accepted, including under simultaneous reads and writes on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common read/write clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| mode_sel | input | 1 | Mode select, sampled during reset (0 request, 1 prefetch) |
| wr_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Write data |
| rd_n | input | 1 | Read enable, active low |
| rd_data | output | WIDTH | Registered read data |
| rd_flag | output | 1 | Request mode: data present (high). Prefetch mode: output not valid (high) |
| wr_flag | output | 1 | Request mode: space available (high). Prefetch mode: full (high) |

## Verification
The hardest situation to reach is the prefetch boundary where the last stored word is shown and memory is empty. A same-edge read and write there must hand the new word through memory without loss or reordering. The full boundary with the shown word included is equally hard to hit. Directed phases fill the FIFO past capacity, read once at full and drain through empty. Random phases then use biased write and read probabilities, so that occupancy repeatedly hovers around both 0/1 and DEPTH-1/DEPTH. Every cycle is compared with a queue-based model in the bench.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic [1:0] {
        ST_REQ     = 2'd0,
        ST_PF_IDLE = 2'd1,
        ST_PF_SHOW = 2'd2
    } rd_state_e;

endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
        end
    end

    assign head_data = mem[rptr];

endmodule

// File: rtl/dmf_occ.sv
module dmf_occ #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic holding,
    output logic mem_nz,
    output logic full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW:0] CAP = (CW + 1)'(DEPTH);

    logic [CW-1:0] count;
    logic [CW:0]   total;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        total  = {1'b0, count} + {{CW{1'b0}}, holding};
        mem_nz = (count != '0);
        full   = (total >= CAP);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, count} <= CAP);                                     // R9
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (count <= $past(count)));                         // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_nz |=> (count <= 1));                                 // R8

endmodule

// File: rtl/dmf_rdctl.sv
module dmf_rdctl
    import dmf_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             rd_n,
    input  logic             mem_nz,
    input  logic [WIDTH-1:0] head_data,
    output logic             pop,
    output logic             holding,
    output logic             pf_mode,
    output logic [WIDTH-1:0] dout
);
    rd_state_e state, state_nx;
    logic      load;

    // next state and datapath control
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_REQ: begin
                load = !rd_n && mem_nz;
            end
            ST_PF_IDLE: begin
                if (mem_nz) begin          // autoload
                    load     = 1'b1;
                    state_nx = ST_PF_SHOW;
                end
            end
            ST_PF_SHOW: begin
                if (!rd_n) begin
                    if (mem_nz) begin      // advance
                        load = 1'b1;
                    end else begin         // drain
                        state_nx = ST_PF_IDLE;
                    end
                end
            end
            default: state_nx = ST_REQ;
        endcase
    end

    // state register; mode pin captured while reset is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= mode_sel ? ST_PF_IDLE : ST_REQ;
        end else begin
            state <= state_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= head_data;
        end
    end

    assign pop     = load;
    assign holding = (state == ST_PF_SHOW);
    assign pf_mode = (state != ST_REQ);

    AST_MODE_LOCK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ) |=> (state == ST_REQ));                  // R1
    AST_MODE_LOCK_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_REQ) |=> (state != ST_REQ));                  // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ && rd_n) |=> $stable(dout));              // R4
    AST_PF_AUTOLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PF_IDLE && mem_nz) |=> (state == ST_PF_SHOW)); // R5
    AST_PF_KEEP_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PF_SHOW && rd_n) |=> ((state == ST_PF_SHOW) && $stable(dout))); // R6
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> mem_nz);                                           // R8

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_flag,
    output logic             wr_flag
);
    logic push;
    logic pop;
    logic holding;
    logic pf_mode;
    logic mem_nz;
    logic full;
    logic [WIDTH-1:0] head_data;

    assign push = !wr_n && !full;

    dmf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head_data)
    );

    dmf_occ #(.DEPTH(DEPTH)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .holding (holding),
        .mem_nz  (mem_nz),
        .full    (full)
    );

    dmf_rdctl #(.WIDTH(WIDTH)) u_rdctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .rd_n      (rd_n),
        .mem_nz    (mem_nz),
        .head_data (head_data),
        .pop       (pop),
        .holding   (holding),
        .pf_mode   (pf_mode),
        .dout      (rd_data)
    );

    assign rd_flag = pf_mode ? !holding : mem_nz;
    assign wr_flag = pf_mode ? full : !full;

    AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !wr_n && rd_n) |=> (full));                       // R9
    AST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_n && pop && !pf_mode) |=> !full);              // R10

endmodule

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;
    localparam int W = 18;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_sel = 1'b0;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         rd_flag;
    logic         wr_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit pf = 0;
    bit toggle_pin = 0;

    logic [W-1:0] mq[$];
    logic [W-1:0] exp_dout;
    bit           shown;

    always #2 clk = ~clk;

    dual_mode_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .wr_n(wr_n), .wr_data(wr_data), .rd_n(rd_n),
        .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_rd_flag();
        if (pf) return !shown;
        return mq.size() != 0;
    endfunction

    function automatic bit exp_wr_flag();
        if (pf) return (mq.size() + int'(shown)) == D;
        return mq.size() != D;
    endfunction

    task automatic model_edge(input logic w, input logic r, input logic [W-1:0] d);
        bit full_now;
        full_now = pf ? ((mq.size() + int'(shown)) == D) : (mq.size() == D);
        if (!pf) begin
            if (!r && mq.size() != 0) exp_dout = mq.pop_front();
        end else if (shown) begin
            if (!r) begin
                if (mq.size() != 0) exp_dout = mq.pop_front();
                else shown = 0;
            end
        end else if (mq.size() != 0) begin
            exp_dout = mq.pop_front();
            shown = 1;
        end
        if (!w && !full_now) mq.push_back(d);
    endtask

    task automatic compare(input string tag);
        chk(32'(rd_data), 32'(exp_dout), tag, "rd_data");
        chk(32'(rd_flag), 32'(exp_rd_flag()), tag, "rd_flag");
        chk(32'(wr_flag), 32'(exp_wr_flag()), tag, "wr_flag");
    endtask

    task automatic step(input logic w, input logic r, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        wr_n = w; rd_n = r; wr_data = d;
        if (toggle_pin) mode_sel = 1'($urandom % 2);
        @(posedge clk);
        #1;
        model_edge(w, r, d);
        compare(tag);
    endtask

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; wr_n = 1'b1; rd_n = 1'b1; toggle_pin = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pf = m; mq.delete(); shown = 0; exp_dout = '0;
        #1;
        compare("R2");                       // R2 reset state
    endtask

    task automatic random_run(input int n, input int pw, input int pr, input string tag);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 100) >= pw, ($urandom % 100) >= pr, W'($urandom), tag);
        end
    endtask

    task automatic run_mode(input bit m);
        string tf;
        do_reset(m);
        tf = m ? "R6" : "R4";
        step(1, 0, '0, "R8");                        // R8 read empty ignored
        step(1, 0, '0, "R8");
        step(0, 1, W'(18'h1A5), m ? "R5" : "R3");    // first word, no read
        step(1, 1, '0, m ? "R5" : "R4");             // R5 autoload / R4 stays
        step(1, 1, '0, m ? "R5" : "R4");
        for (int i = 0; i < D + 3; i++)              // fill past capacity
            step(0, 1, W'(18'h200 + i), m ? "R7" : "R9");
        step(0, 1, W'(18'h3FF), "R9");              // R9 full write dropped
        step(1, 0, '0, "R10");                       // R10 read at full
        step(0, 1, W'(18'h155), "R10");              // accepted write
        step(0, 1, W'(18'h156), "R9");
        for (int i = 0; i < D + 3; i++)              // drain
            step(1, 0, '0, tf);
        step(1, 0, '0, "R8");
        step(0, 0, W'(18'h0AB), "R11");              // same-edge at empty
        step(0, 0, W'(18'h0AC), "R11");
        step(1, 0, '0, "R11");
        step(1, 0, '0, "R11");
        toggle_pin = 1;                              // R1 pin ignored after reset
        random_run(400, 50, 50, "R1");
        toggle_pin = 0;
        random_run(800, 70, 30, m ? "R7" : "R3");    // hover near full
        random_run(800, 30, 70, tf);                 // hover near empty
        random_run(1000, 50, 50, "R11");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_mode(0);
        run_mode(1);
        run_mode(0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule